// File: doc/BRIEF.md
# USB Endpoint Ping-Pong Bank and Token Suspend Control

This block sits between a CPU register port and a USB serial interface engine. For a small window of double-buffered endpoints it keeps one even/odd bit each and steers every transaction to the even or odd buffer-descriptor bank. Every other endpoint always uses the even bank. After each completed transaction it keeps a snapshot of the direction and the bank that were used. When a setup token completes, it freezes the engine until software releases it.

Software reaches the block through two byte-wide registers on a one-bit select. The control register (select 0) holds the module enable at bit 0, a self-clearing bank-reset strobe at bit 1, the resume drive at bit 2 and the token-hold flag at bit 5. The status register (select 1) is read-only and holds the bank of the last transaction at bit 2 and its direction at bit 3. The engine reports each finished transaction with its endpoint number, an IN flag and a setup flag. It asks for the bank of the token in progress through a lookup port.

Top module: `ep_bank_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `sie_run` and `resume_out` are 0, and `bank_odd` is 0 for every endpoint.
- R2: A completion with `done_setup`=1, accepted while enabled, sets the token-hold flag (control bit 5). From the next cycle `sie_run` is 0. A software write in the same cycle does not stop the flag being set.
- R3: Writing control bit 5 as 0 releases the hold, so `sie_run` becomes 1 the next cycle if the module is enabled. `sie_run` is always enable AND NOT hold.
- R4: Each accepted completion on an endpoint in the double-buffered window (endpoints 5 and 6 by default) inverts that endpoint's bank bit. `bank_odd` shows the bank bit of endpoint `tok_ep`.
- R5: For any endpoint outside the window, `bank_odd` is 0 at all times, and completions on that endpoint change no bank bit.
- R6: Writing control bit 1 as 1 clears every bank bit in the next cycle. Bit 1 always reads back 0. If a completion arrives in the same cycle, the clear wins and the bank bit ends at 0.
- R7: A write that moves control bit 0 from 0 to 1 also clears every bank bit. While bit 0 is 0, `sie_run` is 0.
- R8: While the module is disabled, completions are ignored: status, bank bits and the hold flag keep their values.
- R9: An accepted completion sets status bit 3 to its IN flag and status bit 2 to the bank it used, meaning the bank bit before the toggle (0 for endpoints outside the window).
- R10: `resume_out` equals control bit 2 and changes only on a write to the control register.
- R11: Control reads return only bits 5, 2 and 0, and status reads return only bits 3 and 2. All other bits read 0, and writes with select 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| done_vld | input | 1 | Transaction-complete event from the engine |
| done_ep | input | EP_W | Endpoint of the completed transaction |
| done_in | input | 1 | Completed transaction was IN (transmit) |
| done_setup | input | 1 | Completed transaction was a setup token |
| tok_ep | input | EP_W | Endpoint whose bank is being looked up |
| bank_odd | output | 1 | Bank select for `tok_ep`: 1 odd, 0 even |
| sie_run | output | 1 | Engine may process tokens |
| resume_out | output | 1 | Drive resume signalling |

## Verification
The hardest case to reach is a bank-reset write and a completion on a double-buffered endpoint in the same cycle, after that endpoint's bit has already been driven to 1. The directed prologue toggles endpoint 5 to odd and then issues that collision. It also brings about a disable, then completions while disabled, then a re-enable with bits set. The random phase then draws endpoints from 0 to 7, so that about a quarter of the events land in the window. It keeps the enable bit set on most writes, so collisions among writes, setups and completions keep happening.

// File: rtl/ep_bank_pkg.sv
`timescale 1ns/1ps
package ep_bank_pkg;
    // control register bit positions (software-visible layout)
    localparam int CTL_EN_BIT     = 0;
    localparam int CTL_BANKRST_BIT = 1;
    localparam int CTL_RESUME_BIT = 2;
    localparam int CTL_HOLD_BIT   = 5;
    // status register bit positions
    localparam int STS_ODD_BIT    = 2;
    localparam int STS_IN_BIT     = 3;

    typedef struct packed {
        logic en;
        logic resume;
        logic hold;
        logic last_in;
        logic last_odd;
    } ctl_state_t;
endpackage

// File: rtl/ep_pp_bank.sv
`timescale 1ns/1ps
module ep_pp_bank #(
    parameter int EP_W     = 4,
    parameter int PP_FIRST = 5,
    parameter int PP_COUNT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            upd_vld,
    input  logic [EP_W-1:0] upd_ep,
    input  logic [EP_W-1:0] look_ep,
    output logic            upd_odd,
    output logic            look_odd
);
    typedef struct packed {
        logic [PP_COUNT-1:0] odd;
    } pp_state_t;

    pp_state_t state_d, state_q;

    always_comb begin
        state_d  = state_q;
        upd_odd  = 1'b0;
        look_odd = 1'b0;
        for (int i = 0; i < PP_COUNT; i++) begin
            if (upd_ep == EP_W'(PP_FIRST + i)) begin
                upd_odd = state_q.odd[i];
                if (upd_vld) state_d.odd[i] = ~state_q.odd[i];
            end
            if (look_ep == EP_W'(PP_FIRST + i)) look_odd = state_q.odd[i];
        end
        if (clear) state_d.odd = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/ep_ctl_regs.sv
`timescale 1ns/1ps
module ep_ctl_regs
    import ep_bank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              done_vld,
    input  logic              done_in,
    input  logic              done_setup,
    input  logic              upd_odd,
    output logic              accept,
    output logic              bank_clr,
    output logic              en,
    output logic              hold,
    output logic              resume,
    output logic              last_in,
    output logic              last_odd,
    output logic [DATA_W-1:0] reg_rdata
);
    ctl_state_t state_d, state_q;
    logic ctl_wr;
    logic en_rise;

    always_comb begin
        ctl_wr   = reg_wr && (reg_sel == 1'b0);
        accept   = done_vld && state_q.en;
        en_rise  = ctl_wr && reg_wdata[CTL_EN_BIT] && !state_q.en;
        bank_clr = (ctl_wr && reg_wdata[CTL_BANKRST_BIT]) || en_rise;

        state_d = state_q;
        if (ctl_wr) begin
            state_d.en     = reg_wdata[CTL_EN_BIT];
            state_d.resume = reg_wdata[CTL_RESUME_BIT];
            state_d.hold   = reg_wdata[CTL_HOLD_BIT];
        end
        if (accept) begin
            state_d.last_in  = done_in;
            state_d.last_odd = upd_odd;
            if (done_setup) state_d.hold = 1'b1;
        end

        reg_rdata = '0;
        if (reg_sel == 1'b0) begin
            reg_rdata[CTL_EN_BIT]     = state_q.en;
            reg_rdata[CTL_RESUME_BIT] = state_q.resume;
            reg_rdata[CTL_HOLD_BIT]   = state_q.hold;
        end else begin
            reg_rdata[STS_ODD_BIT] = state_q.last_odd;
            reg_rdata[STS_IN_BIT]  = state_q.last_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign en       = state_q.en;
    assign hold     = state_q.hold;
    assign resume   = state_q.resume;
    assign last_in  = state_q.last_in;
    assign last_odd = state_q.last_odd;
endmodule

// File: rtl/ep_bank_ctrl.sv
`timescale 1ns/1ps
module ep_bank_ctrl #(
    parameter int EP_W     = 4,
    parameter int PP_FIRST = 5,
    parameter int PP_COUNT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_sel,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic            done_vld,
    input  logic [EP_W-1:0] done_ep,
    input  logic            done_in,
    input  logic            done_setup,
    input  logic [EP_W-1:0] tok_ep,
    output logic            bank_odd,
    output logic            sie_run,
    output logic            resume_out
);
    logic accept_w, clr_w, upd_odd_w;
    logic en_w, hold_w, resume_w, last_in_w, last_odd_w;

    ep_ctl_regs #(.DATA_W(8)) ctl_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .done_vld(done_vld), .done_in(done_in), .done_setup(done_setup),
        .upd_odd(upd_odd_w),
        .accept(accept_w), .bank_clr(clr_w),
        .en(en_w), .hold(hold_w), .resume(resume_w),
        .last_in(last_in_w), .last_odd(last_odd_w),
        .reg_rdata(reg_rdata)
    );

    ep_pp_bank #(.EP_W(EP_W), .PP_FIRST(PP_FIRST), .PP_COUNT(PP_COUNT)) pp_i (
        .clk(clk), .rst_n(rst_n),
        .clear(clr_w), .upd_vld(accept_w), .upd_ep(done_ep),
        .look_ep(tok_ep), .upd_odd(upd_odd_w), .look_odd(bank_odd)
    );

    assign sie_run    = en_w && !hold_w;
    assign resume_out = resume_w;
endmodule

// File: rtl/ep_bank_ctrl_chk.sv
`timescale 1ns/1ps
module ep_bank_ctrl_chk #(
    parameter int EP_W     = 4,
    parameter int PP_FIRST = 5,
    parameter int PP_COUNT = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic            reg_sel,
    input logic [7:0]      reg_wdata,
    input logic            done_vld,
    input logic            done_setup,
    input logic [EP_W-1:0] tok_ep,
    input logic            bank_odd,
    input logic            sie_run,
    input logic            resume_out,
    input logic            en,
    input logic            last_in,
    input logic            last_odd
);
    logic outside;
    assign outside = (int'(tok_ep) < PP_FIRST) || (int'(tok_ep) >= PP_FIRST + PP_COUNT);

    assert_setup_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && done_setup && en) |=> !sie_run);

    assert_nonpp_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        outside |-> !bank_odd);

    assert_bankrst_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata[1]) |=> !bank_odd);

    assert_enable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> !bank_odd);

    assert_run_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !sie_run);

    assert_disabled_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && done_vld) |=> ($stable(last_in) && $stable(last_odd)));

    assert_resume_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && !reg_sel) |=> $stable(resume_out));
endmodule

bind ep_bank_ctrl ep_bank_ctrl_chk #(.EP_W(EP_W), .PP_FIRST(PP_FIRST), .PP_COUNT(PP_COUNT)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .done_vld(done_vld), .done_setup(done_setup), .tok_ep(tok_ep),
    .bank_odd(bank_odd), .sie_run(sie_run), .resume_out(resume_out),
    .en(en_w), .last_in(last_in_w), .last_odd(last_odd_w)
);

// File: tb/ep_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module ep_bank_ctrl_tb_top;
    localparam int EP_W     = 4;
    localparam int PP_FIRST = 5;
    localparam int PP_COUNT = 2;
    localparam int NEP      = 1 << EP_W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0]      reg_wdata = '0, reg_rdata;
    logic            done_vld = 1'b0, done_in = 1'b0, done_setup = 1'b0;
    logic [EP_W-1:0] done_ep = '0, tok_ep = '0;
    logic            bank_odd, sie_run, resume_out;

    ep_bank_ctrl #(.EP_W(EP_W), .PP_FIRST(PP_FIRST), .PP_COUNT(PP_COUNT)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done_vld(done_vld), .done_ep(done_ep), .done_in(done_in), .done_setup(done_setup),
        .tok_ep(tok_ep), .bank_odd(bank_odd), .sie_run(sie_run), .resume_out(resume_out)
    );

    int n_vec = 0, n_bad = 0;
    bit done_flag = 0;
    bit m_pp[NEP];
    bit m_en, m_res, m_hold, m_in, m_odd;

    function automatic bit is_pp(int ep);
        return ep >= PP_FIRST && ep < PP_FIRST + PP_COUNT;
    endfunction
    function automatic logic [7:0] exp_ctl();
        return {2'b00, m_hold, 2'b00, m_res, 1'b0, m_en};
    endfunction
    function automatic logic [7:0] exp_sts();
        return {4'b0000, m_in, m_odd, 2'b00};
    endfunction

    task automatic chk(string req, int got, int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_all();
        reg_wr = 1'b0; done_vld = 1'b0; reg_sel = 1'b0;
        #0.1 chk("R11 control readback", reg_rdata, exp_ctl());
        chk("R10 resume_out", resume_out, m_res);
        chk("R3 sie_run", sie_run, m_en && !m_hold);
        reg_sel = 1'b1;
        #0.1 chk("R9 status readback", reg_rdata, exp_sts());
        for (int ep = 0; ep < NEP; ep++) begin
            tok_ep = EP_W'(ep);
            #0.05;
            if (is_pp(ep)) chk("R4 bank bit", bank_odd, m_pp[ep]);
            else           chk("R5 even-only endpoint", bank_odd, 0);
        end
    endtask

    task automatic step(bit wr, bit sel, logic [7:0] wd, bit dv, int ep, bit din, bit setup);
        bit ctl_wr, rise, clr, acc;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        done_vld = dv; done_ep = EP_W'(ep); done_in = din; done_setup = setup;
        @(posedge clk);
        ctl_wr = wr && !sel;
        rise   = ctl_wr && wd[0] && !m_en;
        clr    = (ctl_wr && wd[1]) || rise;
        acc    = dv && m_en;
        if (ctl_wr) begin m_en = wd[0]; m_res = wd[2]; m_hold = wd[5]; end
        if (acc) begin
            m_in  = din;
            m_odd = is_pp(ep) ? m_pp[ep] : 1'b0;
            if (is_pp(ep)) m_pp[ep] = !m_pp[ep];
            if (setup) m_hold = 1'b1;
        end
        if (clr) for (int k = 0; k < NEP; k++) m_pp[k] = 1'b0;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NEP; k++) m_pp[k] = 1'b0;
        {m_en, m_res, m_hold, m_in, m_odd} = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all();
        chk("R1 run after reset", sie_run, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();
        // R8: events before enable are ignored
        step(0, 0, 8'h00, 1, 5, 1, 1);
        // R7: enable
        step(1, 0, 8'h01, 0, 0, 0, 0);
        // R4: toggles on endpoint 5 and 6; R9 snapshot
        step(0, 0, 8'h00, 1, 5, 0, 0);
        step(0, 0, 8'h00, 1, 5, 1, 0);
        step(0, 0, 8'h00, 1, 5, 0, 0);
        step(0, 0, 8'h00, 1, 6, 1, 0);
        // R5: endpoint outside window
        step(0, 0, 8'h00, 1, 2, 1, 0);
        // R2: setup holds the engine, R3: release
        step(0, 0, 8'h00, 1, 0, 0, 1);
        step(1, 0, 8'h01, 0, 0, 0, 0);
        // R2: setup plus clearing write in the same cycle: hold stays
        step(1, 0, 8'h01, 1, 6, 0, 1);
        step(1, 0, 8'h01, 0, 0, 0, 0);
        // R6: bank reset collides with a completion on endpoint 5 (bit is 1)
        step(1, 0, 8'h03, 1, 5, 0, 0);
        // R10: resume on and off
        step(1, 0, 8'h05, 0, 0, 0, 0);
        step(0, 0, 8'h00, 0, 0, 0, 0);
        step(1, 0, 8'h01, 0, 0, 0, 0);
        // R7: disable with bit set, R8 ignored, re-enable clears
        step(0, 0, 8'h00, 1, 6, 1, 0);
        step(1, 0, 8'h00, 0, 0, 0, 0);
        step(0, 0, 8'h00, 1, 6, 0, 1);
        step(0, 0, 8'h00, 1, 5, 1, 0);
        step(1, 0, 8'h01, 0, 0, 0, 0);
        // R11: write to status select has no effect
        step(1, 1, 8'hFF, 0, 0, 0, 0);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] wd;
            wd = 8'($urandom);
            if ($urandom % 4 != 0) wd[0] = 1'b1;
            if ($urandom % 3 != 0) wd[5] = 1'b0;
            if ($urandom % 4 != 0) wd[1] = 1'b0;
            step(($urandom % 5) == 0, ($urandom % 4) == 0, wd,
                 ($urandom % 2) == 0, int'($urandom % 8), ($urandom % 2) == 0,
                 ($urandom % 8) == 0);
        end
        done_flag = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule